// File: doc/BRIEF.md
# Page Write Protection Unit

This block decides, for every memory access on a 20-bit word-addressed bus, whether a write targets a page that is locked against the current bus master, and whether any access falls into a memory block that is not populated. The address space is cut into 1024 pages of 1K words. Two independent one-bit-per-page lock maps are kept: one governs processor writes, the other governs DMA writes. The bus-master input picks which map is consulted. A separate table of sixteen 64K-word blocks marks regions that are absent, and this absent-block check can be switched on or off.

An access is announced by a one-cycle valid pulse that carries the address, the direction and the master type. The verdict is held until the next valid pulse. Each error output is a registered copy of the data strobe, gated by the held verdict. An error output therefore rises one cycle after the strobe rises and falls one cycle after it falls, so the error pulse is as wide as the strobe pulse.

The maps are held in synchronous RAM. After reset a sequencer spends one cycle per page writing zeros into both maps. Maps, the block table and the check enable are all loaded through a single-cycle configuration write port.

Top module: `page_guard`

## Requirements
- R1: After reset both error outputs are low, and once the clearing period has ended no page of either map is locked and no block is absent, so no access raises either output.
- R2: For an access with `bus_dma`=0, the page index is `bus_addr[19:10]`, and a write to a page whose processor-map bit is 1 raises `prot_flag`.
- R3: For an access with `bus_dma`=1, the DMA map is used instead, and it is independent of the processor map: a page can be locked for one master and open for the other.
- R4: Reads (`bus_write`=0) never raise `prot_flag`, whatever the maps hold.
- R5: When the absent-block check is enabled, any access, read or write, whose block index `bus_addr[19:16]` is marked absent raises `unimp_flag`. When the check is disabled, `unimp_flag` stays low. The check is enabled at reset.
- R6: While a verdict is set, each error output is high in exactly the cycles that follow a cycle in which `strobe` was sampled high, so the error pulse is as long as the strobe pulse. The output is low in the cycle after `strobe` is sampled low.
- R7: Only a cycle with `bus_valid`=1 starts a new check. Changing the address, direction or master type without `bus_valid` leaves the held verdict unchanged.
- R8: For the 1024 cycles after reset, while the maps are being cleared, writes to either page map are dropped and every lookup reports the page as unlocked.
- R9: Configuration selector `cfg_sel` values: 0 writes `cfg_bit` into the processor map at page `cfg_idx`; 1 writes it into the DMA map; 2 writes it into the block table at block `cfg_idx[3:0]` (1 = absent); 3 sets the absent-block check enable to `cfg_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_sel | input | 2 | Configuration target: 0 processor map, 1 DMA map, 2 block table, 3 check enable |
| cfg_idx | input | 10 | Page index, or block index in the low 4 bits |
| cfg_bit | input | 1 | Value written |
| bus_valid | input | 1 | Pulse that starts a check of the access on the bus |
| bus_write | input | 1 | 1 = write access |
| bus_dma | input | 1 | Master type: 1 = DMA, 0 = processor |
| bus_addr | input | 20 | Word address of the access |
| strobe | input | 1 | Data strobe, active high |
| prot_flag | output | 1 | Write to a locked page, registered |
| unimp_flag | output | 1 | Access to an absent block, registered |

## Verification
Directed writes and reads go to the same page under both master types. A page locked in only one map separates a correct map choice from a swapped one, and the read-versus-write pairs separate a direction check from a missing one. Strobes of one to four cycles are counted against the error pulse width, and an address change without a valid pulse shows whether the verdict is held. Random configuration writes are mixed with random accesses over a pool of pages spread across all sixteen blocks, toggling the absent-block enable along the way. A write issued during the clearing period, followed by a write to the same page after it, shows that writes are dropped during the clear rather than merely hidden.

// File: rtl/page_guard_pkg.sv
package page_guard_pkg;
  typedef enum logic [1:0] {
    CFG_CPU = 2'd0,
    CFG_DMA = 2'd1,
    CFG_BLK = 2'd2,
    CFG_CHK = 2'd3
  } cfg_sel_t;

  localparam int MAP_CPU  = 0;
  localparam int MAP_DMA  = 1;
  localparam int NUM_MAPS = 2;
endpackage

// File: rtl/page_map_ram.sv
// One-bit-wide page map, written and read synchronously so block RAM fits.
module page_map_ram #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic             wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic             rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_guard_clr.sv
// Walks every page index once after reset so the maps can be zeroed.
module page_guard_clr #(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  output logic             busy,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1;
      ptr  <= '0;
    end else if (busy) begin
      if (ptr == LAST) busy <= 1'b0;
      ptr <= ptr + 1'b1;
    end
  end
endmodule

// File: rtl/page_guard_blk.sv
// Absent-block table and the enable for its check, held in resettable flops.
module page_guard_blk #(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tbl_we,
  input  logic [BLK_W-1:0] tbl_idx,
  input  logic             tbl_bit,
  input  logic             en_we,
  input  logic             en_bit,
  input  logic [BLK_W-1:0] look_idx,
  output logic             absent
);
  localparam int NBLK = 1 << BLK_W;

  logic [NBLK-1:0] tbl_q;
  logic            en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_q <= '0;
      en_q  <= 1'b1;
    end else begin
      if (tbl_we) tbl_q[tbl_idx] <= tbl_bit;
      if (en_we)  en_q <= en_bit;
    end
  end

  assign absent = en_q & tbl_q[look_idx];
endmodule

// File: rtl/page_guard.sv
module page_guard
  import page_guard_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int PAGE_W = 10,
  parameter int BLK_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_sel,
  input  logic [ADDR_W-PAGE_W-1:0] cfg_idx,
  input  logic                     cfg_bit,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic                     bus_dma,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic                     strobe,
  output logic                     prot_flag,
  output logic                     unimp_flag
);
  localparam int IDX_W = ADDR_W - PAGE_W;

  logic             clr_busy;
  logic [IDX_W-1:0] clr_ptr;
  logic [IDX_W-1:0] look_page;
  logic [BLK_W-1:0] look_blk;
  logic             blk_absent;
  logic [NUM_MAPS-1:0] map_rd;

  assign look_page = bus_addr[ADDR_W-1 -: IDX_W];
  assign look_blk  = bus_addr[ADDR_W-1 -: BLK_W];

  page_guard_clr #(.IDX_W(IDX_W)) u_clr (
    .clk  (clk),
    .rst  (rst),
    .busy (clr_busy),
    .ptr  (clr_ptr)
  );

  // One map per master type; the sweep overrides configuration writes.
  for (genvar m = 0; m < NUM_MAPS; m++) begin : g_map
    localparam logic [1:0] SEL_CODE = 2'(m);
    logic             w_en;
    logic [IDX_W-1:0] w_addr;
    logic             w_data;

    assign w_en   = clr_busy | (cfg_we & (cfg_sel == SEL_CODE));
    assign w_addr = clr_busy ? clr_ptr : cfg_idx;
    assign w_data = clr_busy ? 1'b0 : cfg_bit;

    page_map_ram #(.IDX_W(IDX_W)) u_ram (
      .clk   (clk),
      .we    (w_en),
      .waddr (w_addr),
      .wdata (w_data),
      .re    (bus_valid),
      .raddr (look_page),
      .rdata (map_rd[m])
    );
  end

  page_guard_blk #(.BLK_W(BLK_W)) u_blk (
    .clk      (clk),
    .rst      (rst),
    .tbl_we   (cfg_we & (cfg_sel == CFG_BLK)),
    .tbl_idx  (cfg_idx[BLK_W-1:0]),
    .tbl_bit  (cfg_bit),
    .en_we    (cfg_we & (cfg_sel == CFG_CHK)),
    .en_bit   (cfg_bit),
    .look_idx (look_blk),
    .absent   (blk_absent)
  );

  // Access capture, aligned with the RAM read.
  logic acc_q, wr_q, dma_q, ready_q, absent_q;
  // Held verdicts of the last captured access.
  logic hold_prot_q, hold_unimp_q;
  logic fresh_prot, cur_prot, cur_unimp;

  assign fresh_prot = wr_q & ready_q & (dma_q ? map_rd[MAP_DMA] : map_rd[MAP_CPU]);
  assign cur_prot   = acc_q ? fresh_prot : hold_prot_q;
  assign cur_unimp  = acc_q ? absent_q   : hold_unimp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q        <= 1'b0;
      wr_q         <= 1'b0;
      dma_q        <= 1'b0;
      ready_q      <= 1'b0;
      absent_q     <= 1'b0;
      hold_prot_q  <= 1'b0;
      hold_unimp_q <= 1'b0;
      prot_flag    <= 1'b0;
      unimp_flag   <= 1'b0;
    end else begin
      acc_q <= bus_valid;
      if (bus_valid) begin
        wr_q     <= bus_write;
        dma_q    <= bus_dma;
        ready_q  <= ~clr_busy;
        absent_q <= blk_absent;
      end
      if (acc_q) begin
        hold_prot_q  <= fresh_prot;
        hold_unimp_q <= absent_q;
      end
      prot_flag  <= strobe & cur_prot;
      unimp_flag <= strobe & cur_unimp;
    end
  end

  logic unused_low_addr;
  assign unused_low_addr = ^bus_addr[PAGE_W-1:0];
endmodule

// File: rtl/page_guard_chk.sv
module page_guard_chk #(
  parameter int CLR_CYC = 1024
) (
  input logic clk,
  input logic rst,
  input logic bus_valid,
  input logic bus_write,
  input logic strobe,
  input logic prot_flag,
  input logic unimp_flag
);
  logic last_wr;
  int   since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_wr   <= 1'b0;
      since_rst <= 0;
    end else begin
      if (bus_valid) last_wr <= bus_write;
      if (since_rst < CLR_CYC) since_rst <= since_rst + 1;
    end
  end

  a_r6_prot_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    prot_flag |-> $past(strobe));
  a_r6_unimp_follows_strobe: assert property (@(posedge clk) disable iff (rst)
    unimp_flag |-> $past(strobe));
  a_r6_drop_after_strobe: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> (!prot_flag && !unimp_flag));
  a_r4_read_never_locked: assert property (@(posedge clk) disable iff (rst)
    prot_flag |-> $past(last_wr));
  a_r8_silent_while_clearing: assert property (@(posedge clk) disable iff (rst)
    (since_rst < CLR_CYC) |-> !prot_flag);
endmodule

bind page_guard page_guard_chk #(.CLR_CYC(1 << (ADDR_W - PAGE_W))) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .strobe     (strobe),
  .prot_flag  (prot_flag),
  .unimp_flag (unimp_flag)
);

// File: tb/sim_page_guard.sv
`timescale 1ns/1ps
module sim_page_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [9:0]  cfg_idx = '0;
  logic        cfg_bit = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic        bus_dma = 1'b0;
  logic [19:0] bus_addr = '0;
  logic        strobe = 1'b0;
  logic        prot_flag, unimp_flag;

  always #2 clk = ~clk;

  page_guard u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx),
    .cfg_bit(cfg_bit), .bus_valid(bus_valid), .bus_write(bus_write), .bus_dma(bus_dma),
    .bus_addr(bus_addr), .strobe(strobe), .prot_flag(prot_flag), .unimp_flag(unimp_flag)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  int  cyc = 0;
  bit  done = 0;
  bit  cpu_m [1024];
  bit  dma_m [1024];
  bit  blk_m [16];
  bit  chk_en = 1;
  bit  map_ok = 0;

  task automatic check(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit exp_prot(input logic [19:0] a, input bit wr, input bit dma);
    return map_ok && wr && (dma ? dma_m[a[19:10]] : cpu_m[a[19:10]]);
  endfunction

  function automatic bit exp_unimp(input logic [19:0] a);
    return chk_en && blk_m[a[19:16]];
  endfunction

  // R9: sel 0 cpu map, 1 dma map, 2 block table (idx[3:0]), 3 check enable
  task automatic cfg(input logic [1:0] sel, input logic [9:0] idx, input bit b, input bit apply);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_idx = idx; cfg_bit = b;
    @(negedge clk);
    cfg_we = 1'b0;
    if (apply) begin
      case (sel)
        2'd0: cpu_m[idx] = b;
        2'd1: dma_m[idx] = b;
        2'd2: blk_m[idx[3:0]] = b;
        default: chk_en = b;
      endcase
    end
  endtask

  task automatic access(input logic [19:0] a, input bit wr, input bit dma, input int n, input string req);
    bit ep, eu;
    ep = exp_prot(a, wr, dma);
    eu = exp_unimp(a);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_write = wr; bus_dma = dma; strobe = 1'b0;
    @(negedge clk);
    bus_valid = 1'b0; strobe = 1'b1;
    check({req, " R6 quiet before strobe (prot)"}, prot_flag, 1'b0);
    check({req, " R6 quiet before strobe (unimp)"}, unimp_flag, 1'b0);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      check({req, " prot during strobe"}, prot_flag, ep);
      check({req, " unimp during strobe"}, unimp_flag, eu);
      if (k == n) strobe = 1'b0;
    end
    @(negedge clk);
    check({req, " R6 prot low after strobe"}, prot_flag, 1'b0);
    check({req, " R6 unimp low after strobe"}, unimp_flag, 1'b0);
  endtask

  function automatic logic [9:0] pick_page();
    logic [9:0] p;
    p = 10'(($urandom % 16) << 6) | 10'($urandom % 4);
    return p;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_sink;
    seed_sink = $urandom(32'd20240611);
    repeat (4) @(negedge clk);
    check("R1 reset prot", prot_flag, 1'b0);
    check("R1 reset unimp", unimp_flag, 1'b0);
    rst = 1'b0;

    // R8: writes during clearing are dropped, lookups report unlocked
    cfg(2'd0, 10'd3, 1'b1, 1'b0);
    access({10'd3, 10'h155}, 1'b1, 1'b0, 2, "R8 clearing");
    repeat (1100) @(negedge clk);
    map_ok = 1;
    access({10'd3, 10'h155}, 1'b1, 1'b0, 2, "R8 dropped write");

    // R1: empty maps after clear
    access(20'hFFFFF, 1'b1, 1'b1, 1, "R1 empty dma");
    access(20'h00000, 1'b1, 1'b0, 1, "R1 empty cpu");

    // R2 / R3 / R9: lock page 0x2A5 in cpu map only, page 0x011 in dma map only
    cfg(2'd0, 10'h2A5, 1'b1, 1'b1);
    cfg(2'd1, 10'h011, 1'b1, 1'b1);
    access({10'h2A5, 10'h3FF}, 1'b1, 1'b0, 3, "R2 cpu locked");
    access({10'h2A5, 10'h000}, 1'b1, 1'b1, 3, "R3 dma open on cpu-locked page");
    access({10'h011, 10'h123}, 1'b1, 1'b1, 4, "R3 dma locked");
    access({10'h011, 10'h123}, 1'b1, 1'b0, 2, "R2 cpu open on dma-locked page");
    access({10'h2A4, 10'h3FF}, 1'b1, 1'b0, 2, "R2 neighbour page open");

    // R4: reads of locked pages
    access({10'h2A5, 10'h010}, 1'b0, 1'b0, 2, "R4 cpu read");
    access({10'h011, 10'h010}, 1'b0, 1'b1, 2, "R4 dma read");

    // R5 / R9: block 0xA absent
    cfg(2'd2, 10'h00A, 1'b1, 1'b1);
    access(20'hA1234, 1'b0, 1'b0, 3, "R5 absent read");
    access(20'hAFFFF, 1'b1, 1'b1, 1, "R5 absent write");
    access(20'hB0000, 1'b0, 1'b0, 1, "R5 present block");
    cfg(2'd3, 10'h000, 1'b0, 1'b1);
    access(20'hA1234, 1'b0, 1'b0, 2, "R5 check disabled");
    cfg(2'd3, 10'h000, 1'b1, 1'b1);

    // R7: no valid pulse, held verdict unchanged
    access({10'h100, 10'h0}, 1'b1, 1'b0, 1, "R7 setup open");
    @(negedge clk);
    bus_addr = {10'h2A5, 10'h0}; bus_write = 1'b1; bus_dma = 1'b0; strobe = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R7 prot held without valid", prot_flag, 1'b0);
    check("R7 unimp held without valid", unimp_flag, 1'b0);
    strobe = 1'b0;
    @(negedge clk);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 3 == 0) begin
        logic [1:0] s;
        s = 2'($urandom % 4);
        if (s == 2'd2) cfg(s, 10'($urandom % 16), 1'($urandom), 1'b1);
        else cfg(s, pick_page(), 1'($urandom), 1'b1);
      end else begin
        access({pick_page(), 10'($urandom)}, 1'($urandom), 1'($urandom),
               1 + int'($urandom % 4), "R2/R3/R5 random");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule